// File: doc/BRIEF.md
# Application-Aware Row-Hit-First Request Scheduler

This block sits between the cores and the DRAM banks of a memory controller. It keeps a small pool of pending memory requests. Each request carries an identifier, the application that issued it, a target bank and a target row. Every cycle it may send one of them to a bank that is currently free. Requests need not leave in the order they arrived. The scheduler chooses among the waiting requests with a fixed ranking.

The ranking has three levels. A request from an application that outside logic has marked as light (very low memory intensity) beats every request from other applications. Below that, a request that targets the row already open in its bank beats one that would force a row change. Among requests that are still tied, the one that has waited longest goes first. The light-application override keeps a lone request from a light program from waiting behind a burst of row hits from a heavy one. Bank timing and the classification of applications are supplied from outside through the bank status and light-flag inputs.

Top module: `memreq_sched`

## Requirements
- R1: After reset the pool is empty: `enq_ready` is 1 and `issue_valid` is 0, and `issue_valid` stays 0 while no request is held.
- R2: The pool holds DEPTH (default 16) requests. With DEPTH held and nothing issuing, `enq_ready` is 0 and an offered request is not taken. With fewer than DEPTH held, `enq_ready` is 1.
- R3: When the pool is full and a request issues in the same cycle, `enq_ready` is 1 and the offered request takes the freed place.
- R4: A request is never issued to a bank whose `bank_busy` bit is 1. While every held request targets a busy bank, `issue_valid` is 0.
- R5: Among requests of the same light/heavy class, one whose row equals the open row of its bank (with `bank_open_valid` set) issues before one that misses.
- R6: Among requests with equal class and equal hit status, the earliest accepted issues first.
- R7: A request whose application has its bit set in `app_light` (bit index = application number) issues before any request from an unflagged application, even a row hit.
- R8: Among flagged requests, row hits still go before misses.
- R9: Each accepted request issues exactly once, with the id, application, bank and row it was accepted with, and at most one request issues per cycle.
- R10: `issue_hit` is 1 exactly when the issued row equals the open row of its bank and that bank's `bank_open_valid` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| enq_valid | input | 1 | A new request is offered |
| enq_ready | output | 1 | The offered request is taken on this edge |
| enq_id | input | ID_W | Request identifier, returned on issue |
| enq_app | input | APP_W | Issuing application number |
| enq_bank | input | BANK_W | Target bank |
| enq_row | input | ROW_W | Target row |
| bank_busy | input | NUM_BANKS | Bit b set: bank b cannot accept a request |
| bank_open_valid | input | NUM_BANKS | Bit b set: bank b has a row open |
| bank_open_row | input | NUM_BANKS*ROW_W | Open row of bank b at bits [b*ROW_W +: ROW_W] |
| app_light | input | NUM_APPS | Bit a set: application a is light and has top priority |
| issue_valid | output | 1 | A request leaves the pool on this edge |
| issue_id | output | ID_W | Identifier of the issued request |
| issue_app | output | APP_W | Application of the issued request |
| issue_bank | output | BANK_W | Bank of the issued request |
| issue_row | output | ROW_W | Row of the issued request |
| issue_hit | output | 1 | The issued request hits the open row |

## Verification
The checker keeps its own count of the pool contents. On every cycle it checks the occupancy-related handshake (empty means no issue, full blocks intake unless an issue frees a place), that no issue goes to a busy bank, and that the hit flag agrees with the bank status. The ranking itself can only be shown by the bench scenarios. The bench loads requests while banks are held busy, then releases the banks and compares the full issue order against a scoreboard. This covers light over hit, hit over miss, age order, and no loss or duplication through a full-pool swap.

// File: rtl/memreq_pkg.sv
// Shared types for the request scheduler.
// Assumes: a priority class is formed from the light flag (high bit)
// and the row-hit flag (low bit), so a larger class ranks higher.
package memreq_pkg;

    typedef enum logic [1:0] {
        CLS_MISS       = 2'b00,
        CLS_HIT        = 2'b01,
        CLS_LIGHT_MISS = 2'b10,
        CLS_LIGHT_HIT  = 2'b11
    } prio_cls_t;

    // Build the ranking class of one request.
    function automatic prio_cls_t make_cls(input logic light, input logic hit);
        return prio_cls_t'({light, hit});
    endfunction

endpackage

// File: rtl/memreq_slot.sv
// One place of the request pool.
// Holds a request and its waiting time, and derives its ranking key
// from the live bank status and light flags.
// Assumes: load has priority over clear (a full-pool swap frees and
// refills the same place on one edge); the age saturates.
module memreq_slot
    import memreq_pkg::*;
#(
    parameter int NUM_BANKS = 4,
    parameter int NUM_APPS  = 4,
    parameter int ROW_W     = 8,
    parameter int ID_W      = 8,
    parameter int AGE_W     = 8,
    localparam int BANK_W   = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
    localparam int APP_W    = (NUM_APPS > 1) ? $clog2(NUM_APPS) : 1,
    localparam int KEY_W    = AGE_W + 2
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       load,
    input  logic                       clear,
    input  logic [ID_W-1:0]            in_id,
    input  logic [APP_W-1:0]           in_app,
    input  logic [BANK_W-1:0]          in_bank,
    input  logic [ROW_W-1:0]           in_row,
    input  logic [NUM_BANKS-1:0]       bank_busy,
    input  logic [NUM_BANKS-1:0]       bank_open_valid,
    input  logic [NUM_BANKS*ROW_W-1:0] bank_open_row,
    input  logic [NUM_APPS-1:0]        app_light,
    output logic                       valid,
    output logic [ID_W-1:0]            id,
    output logic [APP_W-1:0]           app,
    output logic [BANK_W-1:0]          bank,
    output logic [ROW_W-1:0]           row,
    output logic                       elig,
    output logic                       hit,
    output logic [KEY_W-1:0]           key
);

    logic [AGE_W-1:0] age_q;
    prio_cls_t        cls;

    // Capture, release and age the held request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid <= 1'b0;
            id    <= '0;
            app   <= '0;
            bank  <= '0;
            row   <= '0;
            age_q <= '0;
        end else if (load) begin
            valid <= 1'b1;
            id    <= in_id;
            app   <= in_app;
            bank  <= in_bank;
            row   <= in_row;
            age_q <= '0;
        end else if (clear) begin
            valid <= 1'b0;
        end else if (valid && (age_q != '1)) begin
            age_q <= age_q + 1'b1;
        end
    end

    // Derive eligibility, hit status and the ranking key.
    always_comb begin
        hit  = bank_open_valid[bank] &&
               (bank_open_row[bank*ROW_W +: ROW_W] == row);
        elig = valid && !bank_busy[bank];
        cls  = make_cls(app_light[app], hit);
        key  = {cls, age_q};
    end

endmodule

// File: rtl/memreq_pick.sv
// Chooses the eligible place with the largest ranking key.
// Assumes: equal keys resolve to the lowest place index.
module memreq_pick #(
    parameter int DEPTH   = 16,
    parameter int KEY_W   = 10,
    localparam int IDX_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic [DEPTH-1:0] elig,
    input  logic [KEY_W-1:0] keys [DEPTH],
    output logic             found,
    output logic [IDX_W-1:0] idx
);

    logic [KEY_W-1:0] best;

    // Linear scan for the highest-ranked eligible place.
    always_comb begin
        found = 1'b0;
        idx   = '0;
        best  = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (elig[i] && (!found || keys[i] > best)) begin
                found = 1'b1;
                idx   = IDX_W'(i);
                best  = keys[i];
            end
        end
    end

endmodule

// File: rtl/memreq_sched.sv
// Request pool with light-application, row-hit, then age ranking.
// Issues at most one request per cycle to a free bank; an issued place
// is reusable on the same edge, so a full pool still accepts a request
// in a cycle that issues.
// Assumes: bank status and light flags are valid every cycle; the issue
// side has no back-pressure.
module memreq_sched
    import memreq_pkg::*;
#(
    parameter int DEPTH     = 16,
    parameter int NUM_BANKS = 4,
    parameter int NUM_APPS  = 4,
    parameter int ROW_W     = 8,
    parameter int ID_W      = 8,
    parameter int AGE_W     = 8,
    localparam int BANK_W   = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
    localparam int APP_W    = (NUM_APPS > 1) ? $clog2(NUM_APPS) : 1,
    localparam int IDX_W    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int KEY_W    = AGE_W + 2
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       enq_valid,
    output logic                       enq_ready,
    input  logic [ID_W-1:0]            enq_id,
    input  logic [APP_W-1:0]           enq_app,
    input  logic [BANK_W-1:0]          enq_bank,
    input  logic [ROW_W-1:0]           enq_row,
    input  logic [NUM_BANKS-1:0]       bank_busy,
    input  logic [NUM_BANKS-1:0]       bank_open_valid,
    input  logic [NUM_BANKS*ROW_W-1:0] bank_open_row,
    input  logic [NUM_APPS-1:0]        app_light,
    output logic                       issue_valid,
    output logic [ID_W-1:0]            issue_id,
    output logic [APP_W-1:0]           issue_app,
    output logic [BANK_W-1:0]          issue_bank,
    output logic [ROW_W-1:0]           issue_row,
    output logic                       issue_hit
);

    logic [DEPTH-1:0]  slot_valid;
    logic [DEPTH-1:0]  slot_elig;
    logic [DEPTH-1:0]  slot_hit;
    logic [DEPTH-1:0]  slot_load;
    logic [DEPTH-1:0]  slot_clear;
    logic [ID_W-1:0]   slot_id   [DEPTH];
    logic [APP_W-1:0]  slot_app  [DEPTH];
    logic [BANK_W-1:0] slot_bank [DEPTH];
    logic [ROW_W-1:0]  slot_row  [DEPTH];
    logic [KEY_W-1:0]  slot_key  [DEPTH];

    logic              pick_found;
    logic [IDX_W-1:0]  pick_idx;
    logic              free_found;
    logic [IDX_W-1:0]  free_idx;
    logic [IDX_W-1:0]  wr_idx;
    logic              enq_fire;

    // Pool places, one instance per entry.
    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        memreq_slot #(
            .NUM_BANKS (NUM_BANKS),
            .NUM_APPS  (NUM_APPS),
            .ROW_W     (ROW_W),
            .ID_W      (ID_W),
            .AGE_W     (AGE_W)
        ) u_slot (
            .clk             (clk),
            .rst_n           (rst_n),
            .load            (slot_load[g]),
            .clear           (slot_clear[g]),
            .in_id           (enq_id),
            .in_app          (enq_app),
            .in_bank         (enq_bank),
            .in_row          (enq_row),
            .bank_busy       (bank_busy),
            .bank_open_valid (bank_open_valid),
            .bank_open_row   (bank_open_row),
            .app_light       (app_light),
            .valid           (slot_valid[g]),
            .id              (slot_id[g]),
            .app             (slot_app[g]),
            .bank            (slot_bank[g]),
            .row             (slot_row[g]),
            .elig            (slot_elig[g]),
            .hit             (slot_hit[g]),
            .key             (slot_key[g])
        );
    end

    // Ranking selector over all places.
    memreq_pick #(
        .DEPTH (DEPTH),
        .KEY_W (KEY_W)
    ) u_pick (
        .elig  (slot_elig),
        .keys  (slot_key),
        .found (pick_found),
        .idx   (pick_idx)
    );

    // Find the lowest empty place for intake.
    always_comb begin
        free_found = 1'b0;
        free_idx   = '0;
        for (int i = DEPTH - 1; i >= 0; i--) begin
            if (!slot_valid[i]) begin
                free_found = 1'b1;
                free_idx   = IDX_W'(i);
            end
        end
    end

    // Intake handshake and per-place load/clear strobes.
    always_comb begin
        enq_ready = free_found || pick_found;
        enq_fire  = enq_valid && enq_ready;
        wr_idx    = free_found ? free_idx : pick_idx;
        for (int i = 0; i < DEPTH; i++) begin
            slot_load[i]  = enq_fire && (wr_idx == IDX_W'(i));
            slot_clear[i] = pick_found && (pick_idx == IDX_W'(i));
        end
    end

    // Drive the issue port from the selected place.
    always_comb begin
        issue_valid = pick_found;
        issue_id    = slot_id[pick_idx];
        issue_app   = slot_app[pick_idx];
        issue_bank  = slot_bank[pick_idx];
        issue_row   = slot_row[pick_idx];
        issue_hit   = slot_hit[pick_idx];
    end

endmodule

// File: rtl/memreq_sched_chk.sv
// Port-level checker for memreq_sched.
// Keeps an independent count of held requests from the handshakes and
// checks intake, bank and hit-flag rules against it every cycle.
// Assumes: bound to every instance of memreq_sched.
module memreq_sched_chk #(
    parameter int DEPTH     = 16,
    parameter int NUM_BANKS = 4,
    parameter int ROW_W     = 8,
    localparam int BANK_W   = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
    localparam int CNT_W    = $clog2(DEPTH + 1)
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       enq_valid,
    input logic                       enq_ready,
    input logic [NUM_BANKS-1:0]       bank_busy,
    input logic [NUM_BANKS-1:0]       bank_open_valid,
    input logic [NUM_BANKS*ROW_W-1:0] bank_open_row,
    input logic                       issue_valid,
    input logic [BANK_W-1:0]          issue_bank,
    input logic [ROW_W-1:0]           issue_row,
    input logic                       issue_hit
);

    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

    logic [CNT_W-1:0] cnt;
    logic             fire;

    assign fire = enq_valid && enq_ready;

    // Track how many requests the block holds.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else
            cnt <= cnt + CNT_W'(fire) - CNT_W'(issue_valid);
    end

    assert_empty_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt == '0) |-> !issue_valid);

    assert_no_overflow_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ((cnt == FULL_CNT) && !issue_valid) |-> !enq_ready);

    assert_room_accepts_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt < FULL_CNT) |-> enq_ready);

    assert_full_swap_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ((cnt == FULL_CNT) && issue_valid) |-> enq_ready);

    assert_bank_free_R4: assert property (@(posedge clk) disable iff (!rst_n)
        issue_valid |-> !bank_busy[issue_bank]);

    assert_hit_flag_R10: assert property (@(posedge clk) disable iff (!rst_n)
        issue_valid |-> (issue_hit == (bank_open_valid[issue_bank] &&
            (bank_open_row[issue_bank*ROW_W +: ROW_W] == issue_row))));

endmodule

bind memreq_sched memreq_sched_chk #(
    .DEPTH     (DEPTH),
    .NUM_BANKS (NUM_BANKS),
    .ROW_W     (ROW_W)
) u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .enq_valid       (enq_valid),
    .enq_ready       (enq_ready),
    .bank_busy       (bank_busy),
    .bank_open_valid (bank_open_valid),
    .bank_open_row   (bank_open_row),
    .issue_valid     (issue_valid),
    .issue_bank      (issue_bank),
    .issue_row       (issue_row),
    .issue_hit       (issue_hit)
);

// File: tb/test_memreq_sched.sv
// Scoreboard bench: scenarios load requests while banks are busy, queue
// the expected issue order, then release banks; a monitor pops and
// compares every issue.
module test_memreq_sched;

    localparam int DEPTH     = 16;
    localparam int NUM_BANKS = 4;
    localparam int NUM_APPS  = 4;
    localparam int ROW_W     = 8;
    localparam int ID_W      = 8;
    localparam int BANK_W    = 2;
    localparam int APP_W     = 2;

    logic                       clk = 1'b0;
    logic                       rst_n = 1'b0;
    logic                       enq_valid = 1'b0;
    logic                       enq_ready;
    logic [ID_W-1:0]            enq_id = '0;
    logic [APP_W-1:0]           enq_app = '0;
    logic [BANK_W-1:0]          enq_bank = '0;
    logic [ROW_W-1:0]           enq_row = '0;
    logic [NUM_BANKS-1:0]       bank_busy = '1;
    logic [NUM_BANKS-1:0]       bank_open_valid = '0;
    logic [NUM_BANKS*ROW_W-1:0] bank_open_row = '0;
    logic [NUM_APPS-1:0]        app_light = '0;
    logic                       issue_valid;
    logic [ID_W-1:0]            issue_id;
    logic [APP_W-1:0]           issue_app;
    logic [BANK_W-1:0]          issue_bank;
    logic [ROW_W-1:0]           issue_row;
    logic                       issue_hit;

    typedef struct {
        int    id;
        int    app;
        int    bank;
        int    row;
        int    hit;
        string req;
    } exp_t;

    exp_t sb[$];
    int   n_tests = 0;
    int   n_fail  = 0;
    bit   done    = 1'b0;

    always #10 clk = ~clk;

    memreq_sched #(
        .DEPTH     (DEPTH),
        .NUM_BANKS (NUM_BANKS),
        .NUM_APPS  (NUM_APPS),
        .ROW_W     (ROW_W),
        .ID_W      (ID_W)
    ) i_memreq_sched (
        .clk             (clk),
        .rst_n           (rst_n),
        .enq_valid       (enq_valid),
        .enq_ready       (enq_ready),
        .enq_id          (enq_id),
        .enq_app         (enq_app),
        .enq_bank        (enq_bank),
        .enq_row         (enq_row),
        .bank_busy       (bank_busy),
        .bank_open_valid (bank_open_valid),
        .bank_open_row   (bank_open_row),
        .app_light       (app_light),
        .issue_valid     (issue_valid),
        .issue_id        (issue_id),
        .issue_app       (issue_app),
        .issue_bank      (issue_bank),
        .issue_row       (issue_row),
        .issue_hit       (issue_hit)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic push_exp(input int id, input int app, input int bank,
                            input int row, input int hit, input string req);
        sb.push_back('{id, app, bank, row, hit, req});
    endtask

    // Offer one request for one cycle; called just after a rising edge.
    task automatic enq(input int id, input int app, input int bank, input int row);
        enq_valid = 1'b1;
        enq_id    = ID_W'(id);
        enq_app   = APP_W'(app);
        enq_bank  = BANK_W'(bank);
        enq_row   = ROW_W'(row);
        @(posedge clk);
        #1;
        enq_valid = 1'b0;
    endtask

    task automatic set_open(input int b, input bit v, input int r);
        bank_open_valid[b]             = v;
        bank_open_row[b*ROW_W +: ROW_W] = ROW_W'(r);
    endtask

    task automatic drain(input int max_cycles);
        for (int c = 0; c < max_cycles && sb.size() != 0; c++) @(posedge clk);
        repeat (2) @(posedge clk);
        #1;
        check(sb.size() == 0, "R9", "pending expected issues", sb.size(), 0);
    endtask

    // Monitor: compare each issue with the head of the scoreboard.
    always @(negedge clk) begin
        if (rst_n && issue_valid) begin
            exp_t e;
            if (sb.size() == 0) begin
                check(1'b0, "R9", "unexpected issue id", int'(issue_id), -1);
            end else begin
                e = sb.pop_front();
                check(int'(issue_id) == e.id, e.req, "issue_id", int'(issue_id), e.id);
                check(int'(issue_app) == e.app, "R9", "issue_app", int'(issue_app), e.app);
                check(int'(issue_bank) == e.bank, "R9", "issue_bank", int'(issue_bank), e.bank);
                check(int'(issue_row) == e.row, "R9", "issue_row", int'(issue_row), e.row);
                check(int'(issue_hit) == e.hit, "R10", "issue_hit", int'(issue_hit), e.hit);
            end
        end
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        #(200000 * 20);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        rst_n = 1'b1;
        @(negedge clk);
        check(enq_ready == 1'b1, "R1", "enq_ready after reset", int'(enq_ready), 1);
        check(issue_valid == 1'b0, "R1", "issue_valid after reset", int'(issue_valid), 0);
        @(posedge clk);
        #1;

        // Scenario: row hits before misses, then age (R5, R6, R4).
        bank_busy = '1;
        set_open(0, 1'b1, 7);
        set_open(1, 1'b0, 0);
        enq(1, 0, 0, 5);
        enq(2, 0, 0, 7);
        enq(3, 1, 0, 7);
        enq(4, 0, 1, 3);
        @(negedge clk);
        check(issue_valid == 1'b0, "R4", "issue while all banks busy", int'(issue_valid), 0);
        push_exp(2, 0, 0, 7, 1, "R5");
        push_exp(3, 1, 0, 7, 1, "R6");
        push_exp(1, 0, 0, 5, 0, "R6");
        push_exp(4, 0, 1, 3, 0, "R6");
        @(posedge clk);
        #1;
        bank_busy = '0;
        drain(20);
        bank_busy = '1;

        // Scenario: light application overrides hits (R7, R8).
        app_light = 4'b0100;
        set_open(0, 1'b1, 7);
        set_open(1, 1'b1, 3);
        set_open(2, 1'b1, 4);
        enq(10, 0, 0, 7);
        enq(11, 2, 1, 9);
        enq(12, 2, 2, 4);
        enq(13, 1, 0, 7);
        push_exp(12, 2, 2, 4, 1, "R8");
        push_exp(11, 2, 1, 9, 0, "R7");
        push_exp(10, 0, 0, 7, 1, "R6");
        push_exp(13, 1, 0, 7, 1, "R6");
        bank_busy = '0;
        drain(20);
        bank_busy = '1;

        // Scenario: light misses beat a heavy hit, in age order (R7, R6).
        app_light = 4'b1000;
        enq(20, 3, 1, 50);
        enq(21, 0, 0, 7);
        enq(22, 3, 2, 60);
        push_exp(20, 3, 1, 50, 0, "R7");
        push_exp(22, 3, 2, 60, 0, "R7");
        push_exp(21, 0, 0, 7, 1, "R7");
        bank_busy = '0;
        drain(20);
        bank_busy = '1;
        app_light = '0;

        // Scenario: full pool, blocked intake, then swap (R2, R3, R9).
        for (int b = 0; b < NUM_BANKS; b++) set_open(b, 1'b0, 0);
        for (int i = 0; i < DEPTH; i++) enq(30 + i, i % NUM_APPS, 0, i);
        @(negedge clk);
        check(enq_ready == 1'b0, "R2", "enq_ready when full", int'(enq_ready), 0);
        enq_valid = 1'b1;
        enq_id    = ID_W'(46);
        enq_app   = '0;
        enq_bank  = '0;
        enq_row   = ROW_W'(99);
        @(posedge clk);
        #1;
        @(negedge clk);
        check(enq_ready == 1'b0, "R2", "enq_ready still full", int'(enq_ready), 0);
        for (int i = 0; i < DEPTH; i++) push_exp(30 + i, i % NUM_APPS, 0, i, 0, "R6");
        push_exp(46, 0, 0, 99, 0, "R3");
        @(posedge clk);
        #1;
        bank_busy[0] = 1'b0;
        @(negedge clk);
        check(enq_ready == 1'b1, "R3", "enq_ready during swap", int'(enq_ready), 1);
        check(issue_valid == 1'b1, "R3", "issue during swap", int'(issue_valid), 1);
        @(posedge clk);
        #1;
        enq_valid = 1'b0;
        drain(40);
        @(negedge clk);
        check(issue_valid == 1'b0, "R1", "issue_valid when drained", int'(issue_valid), 0);
        check(enq_ready == 1'b1, "R2", "enq_ready when drained", int'(enq_ready), 1);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule